// File: doc/BRIEF.md
# Three-Multiplier Complex FIR Filter

This block filters a complex sample stream with N complex taps. It returns the inner product of the conjugated coefficient vector W = c + j·d with the newest N input samples, so the real result is c·Xr + d·Xi and the imaginary result is c·Xi − d·Xr. It does not use four cross-coupled real filters. It forms a difference stream X1 = Xr − Xi for each accepted sample and runs three real sub-filters: c1·Xr, d1·Xi and d·X1. Here c1 = c + d and d1 = c − d are the pre-combined coefficient vectors. The d·X1 term is computed once and subtracted in both outputs. This needs 3N multipliers where the cross-coupled form needs 4N.

Samples arrive on a valid strobe. Coefficient vectors arrive as parallel bus inputs, for example from an adaptation engine elsewhere. The block registers the coefficients on every accepted sample and applies the previous set to the current input vector. This models the one-sample-old weights of an adaptive loop. Full-precision sums are scaled and saturated into one output register.

A two-state machine drives the output strobe. In IDLE, no new result is in the output register. In EMIT, the output register holds a result produced at the last edge. The ACCEPT transition enters EMIT from either state when in_valid is high. The SKIP transition enters IDLE from either state when in_valid is low.

Top module: `sr_cfir`

## Requirements
- R1: After reset, out_valid is 0, both outputs are 0, the delay lines hold zeros and the coefficient registers hold zeros. The first result after reset is therefore 0 whatever the coefficient inputs carry.
- R2: The real, imaginary and difference (X1 = Xr − Xi, one bit wider) delay lines all shift together, and only on a cycle with in_valid high. Samples presented with in_valid low never enter the filter.
- R3: Each result uses the coefficient values sampled at the previous accepted sample. The coefficient registers load only when in_valid is high, so coefficient input values during idle cycles have no effect.
- R4: The full-precision real sum is Σk c1[k]·Xr[k] − Σk d[k]·X1[k]. Tap k takes the signed 16-bit field bits [16k+15:16k] of each coefficient bus. Tap 0 is the sample accepted in the current cycle, and tap k is the sample accepted k samples earlier.
- R5: The full-precision imaginary sum is Σk d1[k]·Xi[k] − Σk d[k]·X1[k], using the same field and tap order as R4.
- R6: Each full-precision sum is shifted arithmetically right by 14 bits (coefficients are Q2.14; the shift rounds toward minus infinity). It is then saturated to the signed 16-bit range [−32768, 32767].
- R7: out_valid is 1 exactly in the cycle after an accepted sample. The outputs then carry that sample's result and keep it until the next accepted sample.
- R8: The state machine follows ACCEPT into EMIT and SKIP into IDLE, and out_valid is 1 only in EMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept strobe for the sample and coefficient inputs |
| xr_in | input | 12 | Real part of the input sample, signed |
| xi_in | input | 12 | Imaginary part of the input sample, signed |
| c1_coef | input | 64 | Vector c + d, N signed Q2.14 fields, tap 0 in the low bits |
| d1_coef | input | 64 | Vector c − d, N signed Q2.14 fields |
| d_coef | input | 64 | Vector d, N signed Q2.14 fields |
| yr_out | output | 16 | Real filter result, signed, saturated |
| yi_out | output | 16 | Imaginary filter result, signed, saturated |
| out_valid | output | 1 | High for one cycle after each accepted sample |

## Verification
The hardest condition to reach from the ports is saturation in both directions. It needs extreme coefficients already in the registers and every tap of the delay line filled with extreme samples of opposite sign on the real and imaginary inputs. Because of the one-sample coefficient lag, the bench loads the extreme coefficient set first, then feeds N+1 identical extreme samples, and then repeats this with the signs reversed. Sweeps with several computed coefficient sets step through the whole 12-bit input range. Idle gaps carry unrelated sample and coefficient values, which shows they never reach the result.

// File: rtl/sr_cfir_pkg.sv
package sr_cfir_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_t;

endpackage

// File: rtl/sr_fir_delay_line.sv
module sr_fir_delay_line #(
    parameter int N = 4,
    parameter int W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift,
    input  logic [W-1:0]   din,
    output logic [N*W-1:0] taps
);
    localparam int HW = (N - 1) * W;

    logic [HW-1:0] hist_q;

    // Tap 0 is the incoming sample, older samples sit above it.
    assign taps = {hist_q, din};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift) begin
            hist_q <= taps[HW-1:0];
        end
    end

    // R2: an accepted sample lands in the first history slot
    a_r2_sample_enters: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> hist_q[W-1:0] == $past(din));

    // R2: history does not move without an accept
    a_r2_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(hist_q));

endmodule

// File: rtl/sr_fir_subfilter.sv
module sr_fir_subfilter #(
    parameter int N  = 4,
    parameter int XW = 12,
    parameter int CW = 16,
    parameter int AW = 32
) (
    input  logic [N*XW-1:0]     taps,
    input  logic [N*CW-1:0]     coefs,
    output logic signed [AW-1:0] sum
);
    localparam int PW = XW + CW;

    logic signed [AW-1:0] prod_ext [N];

    for (genvar k = 0; k < N; k++) begin : g_tap
        logic signed [XW-1:0] x_k;
        logic signed [CW-1:0] c_k;
        logic signed [PW-1:0] p_k;
        assign x_k = $signed(taps[k*XW +: XW]);
        assign c_k = $signed(coefs[k*CW +: CW]);
        assign p_k = x_k * c_k;
        assign prod_ext[k] = {{(AW-PW){p_k[PW-1]}}, p_k};
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < N; k++) begin
            sum = sum + prod_ext[k];
        end
    end

endmodule

// File: rtl/sr_fir_scale_sat.sv
module sr_fir_scale_sat #(
    parameter int AW   = 32,
    parameter int FRAC = 14,
    parameter int OW   = 16
) (
    input  logic signed [AW-1:0] acc,
    output logic signed [OW-1:0] res
);
    localparam longint HI_I = (longint'(1) <<< (OW - 1)) - 1;
    localparam longint LO_I = -(longint'(1) <<< (OW - 1));
    localparam logic signed [AW-1:0] HI = AW'(HI_I);
    localparam logic signed [AW-1:0] LO = AW'(LO_I);

    logic signed [AW-1:0] scaled;

    assign scaled = acc >>> FRAC;

    always_comb begin
        if (scaled > HI) begin
            res = HI[OW-1:0];
        end else if (scaled < LO) begin
            res = LO[OW-1:0];
        end else begin
            res = scaled[OW-1:0];
        end
    end

    // R6: the result keeps the sign of the scaled sum
    always_comb begin
        a_r6_sign_kept: assert (scaled[AW-1] == res[OW-1]);
    end

endmodule

// File: rtl/sr_cfir.sv
module sr_cfir #(
    parameter int N    = 4,
    parameter int XW   = 12,
    parameter int CW   = 16,
    parameter int AW   = 32,
    parameter int OW   = 16,
    parameter int FRAC = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [XW-1:0]  xr_in,
    input  logic [XW-1:0]  xi_in,
    input  logic [N*CW-1:0] c1_coef,
    input  logic [N*CW-1:0] d1_coef,
    input  logic [N*CW-1:0] d_coef,
    output logic [OW-1:0]  yr_out,
    output logic [OW-1:0]  yi_out,
    output logic           out_valid
);
    import sr_cfir_pkg::*;

    localparam int DW = XW + 1;

    emit_state_t state_q, state_d;

    logic signed [DW-1:0] x1_new;
    logic [N*XW-1:0] xr_taps, xi_taps;
    logic [N*DW-1:0] x1_taps;
    logic [N*CW-1:0] c1_q, d1_q, d_q;
    logic signed [AW-1:0] s1, s2, s3, acc_r, acc_i;
    logic signed [OW-1:0] yr_nx, yi_nx;
    logic [OW-1:0] yr_q, yi_q;

    // Difference stream formed once per sample
    assign x1_new = $signed({xr_in[XW-1], xr_in}) - $signed({xi_in[XW-1], xi_in});

    sr_fir_delay_line #(.N(N), .W(XW)) u_line_re (
        .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(xr_in), .taps(xr_taps));

    sr_fir_delay_line #(.N(N), .W(XW)) u_line_im (
        .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(xi_in), .taps(xi_taps));

    sr_fir_delay_line #(.N(N), .W(DW)) u_line_df (
        .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(x1_new), .taps(x1_taps));

    // Coefficient bank: the filter sees the set from the previous accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c1_q <= '0;
            d1_q <= '0;
            d_q  <= '0;
        end else if (in_valid) begin
            c1_q <= c1_coef;
            d1_q <= d1_coef;
            d_q  <= d_coef;
        end
    end

    sr_fir_subfilter #(.N(N), .XW(XW), .CW(CW), .AW(AW)) u_sub_re (
        .taps(xr_taps), .coefs(c1_q), .sum(s1));

    sr_fir_subfilter #(.N(N), .XW(XW), .CW(CW), .AW(AW)) u_sub_im (
        .taps(xi_taps), .coefs(d1_q), .sum(s2));

    sr_fir_subfilter #(.N(N), .XW(DW), .CW(CW), .AW(AW)) u_sub_df (
        .taps(x1_taps), .coefs(d_q), .sum(s3));

    // Shared third term subtracted in both outputs
    assign acc_r = s1 - s3;
    assign acc_i = s2 - s3;

    sr_fir_scale_sat #(.AW(AW), .FRAC(FRAC), .OW(OW)) u_sat_re (.acc(acc_r), .res(yr_nx));
    sr_fir_scale_sat #(.AW(AW), .FRAC(FRAC), .OW(OW)) u_sat_im (.acc(acc_i), .res(yi_nx));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            yr_q <= '0;
            yi_q <= '0;
        end else if (in_valid) begin
            yr_q <= yr_nx;
            yi_q <= yi_nx;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_EMIT);
        yr_out    = yr_q;
        yi_out    = yi_q;
    end

    // R7: strobe follows every accept by one cycle
    a_r7_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7: no strobe after an idle cycle
    a_r7_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: results held between accepts
    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(yr_out) && $stable(yi_out));

    // R3: coefficient bank captures the ports on accept
    a_r3_coef_capture: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (c1_q == $past(c1_coef)) && (d1_q == $past(d1_coef)) && (d_q == $past(d_coef)));

    // R3: coefficient bank ignores the ports while idle
    a_r3_coef_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(c1_q) && $stable(d1_q) && $stable(d_q));

    // R8: EMIT is only entered through ACCEPT
    a_r8_emit_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid));

endmodule

// File: tb/sr_cfir_bench.sv
module sr_cfir_bench;
    localparam int N  = 4;
    localparam int XW = 12;
    localparam int CW = 16;
    localparam int OW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [XW-1:0] xr_in = '0, xi_in = '0;
    logic [N*CW-1:0] c1_coef = '0, d1_coef = '0, d_coef = '0;
    logic [OW-1:0] yr_out, yi_out;
    logic out_valid;

    always #4 clk = ~clk;

    sr_cfir u_sr_cfir (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .xr_in(xr_in), .xi_in(xi_in),
        .c1_coef(c1_coef), .d1_coef(d1_coef), .d_coef(d_coef),
        .yr_out(yr_out), .yi_out(yi_out), .out_valid(out_valid));

    int n_checks = 0;
    int n_fail = 0;
    int hxr [N];
    int hxi [N];
    int cc1 [N], cd1 [N], cd [N];
    int pc1 [N], pd1 [N], pd [N];
    int last_r = 0, last_i = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wrap(input int v, input int w);
        int m;
        m = v & ((1 << w) - 1);
        if (m >= (1 << (w - 1))) m = m - (1 << w);
        return m;
    endfunction

    function automatic int sat16(input longint s);
        longint t;
        t = s >>> 14;
        if (t > 32767) return 32767;
        if (t < -32768) return -32768;
        return int'(t);
    endfunction

    task automatic drive_coefs();
        for (int k = 0; k < N; k++) begin
            c1_coef[k*CW +: CW] = cc1[k][CW-1:0];
            d1_coef[k*CW +: CW] = cd1[k][CW-1:0];
            d_coef[k*CW +: CW]  = cd[k][CW-1:0];
        end
    endtask

    task automatic accept(input int xr, input int xi, input string tag);
        longint s1, s2, s3;
        int er, ei, ar, ai;
        @(negedge clk);
        in_valid = 1'b1;
        xr_in = xr[XW-1:0];
        xi_in = xi[XW-1:0];
        drive_coefs();
        for (int k = N - 1; k > 0; k--) begin
            hxr[k] = hxr[k-1];
            hxi[k] = hxi[k-1];
        end
        hxr[0] = xr;
        hxi[0] = xi;
        s1 = 0; s2 = 0; s3 = 0;
        for (int k = 0; k < N; k++) begin
            s1 += longint'(pc1[k]) * hxr[k];
            s2 += longint'(pd1[k]) * hxi[k];
            s3 += longint'(pd[k]) * (hxr[k] - hxi[k]);
        end
        er = sat16(s1 - s3);
        ei = sat16(s2 - s3);
        for (int k = 0; k < N; k++) begin
            pc1[k] = cc1[k];
            pd1[k] = cd1[k];
            pd[k]  = cd[k];
        end
        @(negedge clk);
        in_valid = 1'b0;
        ar = int'($signed(yr_out));
        ai = int'($signed(yi_out));
        check(out_valid == 1'b1, "R7 R8 out_valid after accept", out_valid, 1);
        check(ar == er, {tag, " R4 real"}, ar, er);
        check(ai == ei, {tag, " R5 imag"}, ai, ei);
        last_r = ar;
        last_i = ai;
    endtask

    task automatic gap(input int cycles, input int seed);
        for (int g = 0; g < cycles; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            xr_in = 12'(seed * 77 + g * 1301);
            xi_in = 12'(seed * 191 + g * 911);
            c1_coef = {4{16'(seed * 4567 + g)}};
            d1_coef = {4{16'(seed * 2345 - g)}};
            d_coef  = {4{16'(seed * 999 + 3 * g)}};
            @(negedge clk);
            check(out_valid == 1'b0, "R7 R8 out_valid in gap", out_valid, 0);
            check(int'($signed(yr_out)) == last_r, "R7 real held", int'($signed(yr_out)), last_r);
            check(int'($signed(yi_out)) == last_i, "R7 imag held", int'($signed(yi_out)), last_i);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) begin
            hxr[k] = 0; hxi[k] = 0;
            pc1[k] = 0; pd1[k] = 0; pd[k] = 0;
            cc1[k] = 0; cd1[k] = 0; cd[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(yr_out == '0, "R1 real after reset", int'($signed(yr_out)), 0);
        check(yi_out == '0, "R1 imag after reset", int'($signed(yi_out)), 0);

        // R1 / R3: first result uses cleared coefficients
        for (int k = 0; k < N; k++) begin
            cc1[k] = 12000 + k; cd1[k] = -9000 + k; cd[k] = 7000 - k;
        end
        accept(1500, -900, "R1 R3 first");

        // Sweeps over several coefficient sets; set change checks R3 lag
        for (int cs = 0; cs < 5; cs++) begin
            for (int k = 0; k < N; k++) begin
                cc1[k] = wrap(cs * 5237 + k * 9001 + 311, 16);
                cd1[k] = wrap(cs * 12011 - k * 7919 + 97, 16);
                cd[k]  = wrap(cs * 3001 + k * 15013 - 4000, 16);
            end
            for (int i = 0; i < 160; i++) begin
                accept(wrap(i * 173 + cs * 31 - 2048, 12), wrap(i * 389 + cs * 7 + 5, 12),
                       (i == 0) ? "R3 lag" : "sweep");
                if (i % 37 == 36) gap(2, i + cs);   // R2 R3: idle data ignored
            end
        end

        // R6: positive saturation on real output
        for (int k = 0; k < N; k++) begin
            cc1[k] = 32767; cd1[k] = 32767; cd[k] = -32768;
        end
        accept(0, 0, "R6 load");
        for (int i = 0; i <= N; i++) accept(2047, -2048, "R6 high");
        check(last_r == 32767, "R6 positive limit", last_r, 32767);
        for (int i = 0; i <= N; i++) accept(-2048, 2047, "R6 low");
        check(last_r == -32768, "R6 negative limit", last_r, -32768);
        gap(3, 99);
        accept(-1, 1, "R6 floor");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule